// File: doc/BRIEF.md
# Burst-Prefetch Multi-Bank Memory Model

This block is a synthesizable behavioural model of a small dynamic memory made of several banks. Each bank has a slow storage array and shares one fast, narrow data path to the pins. When a read request is accepted, the chosen bank spends a fixed number of interface cycles on a core access. That access fetches one wide prefetch word of `BURST_LEN` beats from a single row. A serializer then places that word on the narrow data bus, one beat per cycle.

Every access is a full burst. Beats the requester did not ask for still go out, but they are marked as dropped. Requests are presented on a valid/ready handshake with bank, row and column fields, and the requester interleaves consecutive requests over the banks. A core access to one bank can then run while another bank's burst occupies the pins, which shortens the idle time on the bus.

Storage contents are set at reset from a fixed pattern computed from the address. A bench can therefore predict every beat.

Top module: `pfx_dram_model`

## Requirements
- R1: After reset, `dq_valid`, `dq_first` and `dq_drop` are low, and `req_ready` is high whichever bank `req_bank` selects.
- R2: When the bank and the pins are idle, the first beat of a burst is valid in the cycle that starts `CORE_DELAY`+1 clock edges after the edge that accepted the request.
- R3: Every burst consists of exactly `BURST_LEN` consecutive valid beats. `dq_first` is high on the first beat only, and `dq_first` and `dq_drop` are low whenever `dq_valid` is low.
- R4: The beats of a request with column c cover the aligned group of `BURST_LEN` columns that contains c. Beat k carries column (c with its low log2(`BURST_LEN`) bits cleared) + ((c + k) mod `BURST_LEN`), which wraps inside the group. The data of bank b, row r, column c is (5r + 3c + 7b + 1) mod 2^`DQ_W`.
- R5: When `req_keep_all` was low at acceptance, beats 1 to `BURST_LEN`-1 of the burst have `dq_drop` high. When it was high, no beat has `dq_drop` high. The first beat never has `dq_drop` high.
- R6: `req_ready` is low for a bank from the edge after that bank accepts a request until the edge at which its prefetch word moves to the serializer. A stream of requests to one bank is therefore accepted every `CORE_DELAY`+2 cycles.
- R7: Bursts leave the pins in the order their requests were accepted, and every burst belongs to an accepted request.
- R8: When the next burst's prefetch word is ready before the current burst ends, its first beat follows the current burst's last beat with no idle cycle between them.
- R9: For K requests streamed back to back to one bank (defaults), the last beat is valid `CORE_DELAY`+1+(K-1)(`CORE_DELAY`+2)+`BURST_LEN`-1 edges after the first acceptance. The pins are idle for (K-1)(`CORE_DELAY`+2-`BURST_LEN`) cycles between the first and the last beat.
- R10: For P pairs of requests alternating between two banks (defaults), the last beat is valid `CORE_DELAY`+1+(P-1)(`CORE_DELAY`+2)+2·`BURST_LEN`-1 edges after the first acceptance. The idle count is (P-1)(`CORE_DELAY`+2-2·`BURST_LEN`), which is lower than that of a single-bank stream of the same length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Selected bank can take the request this cycle |
| req_bank | input | log2(NUM_BANKS) | Bank index |
| req_row | input | log2(ROWS) | Row within the bank |
| req_col | input | log2(COLS) | Wanted column within the row |
| req_keep_all | input | 1 | All beats of the burst are wanted |
| dq_data | output | DQ_W | Narrow data beat |
| dq_valid | output | 1 | Beat on `dq_data` is valid |
| dq_first | output | 1 | Beat is the first of its burst |
| dq_drop | output | 1 | Beat was not requested and is to be discarded |

## Verification
The properties assume that `req_bank` only ever names an existing bank, which holds when `NUM_BANKS` is a power of two. They also assume that `COLS` is a whole multiple of `BURST_LEN`, so that a burst group never runs past the end of a row. The bank-lock check relies on an accepted request being followed by the same bank only when the requester really repeats it, so it compares the bank field across the two cycles rather than assuming it is stable. The stimulus uses the default, power-of-two configuration. It changes request fields only at falling edges and holds each request until it is accepted. It waits for every stream to drain before the next scenario starts, so each latency and idle count is measured from empty banks.

// File: rtl/pfx_dram_pkg.sv
package pfx_dram_pkg;

  // Reset-time storage contents, derived from the cell address.
  function automatic int unsigned cell_pattern(input int unsigned bank,
                                               input int unsigned row,
                                               input int unsigned col);
    return row * 5 + col * 3 + bank * 7 + 1;
  endfunction

endpackage

// File: rtl/pfx_rst_sync.sv
module pfx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/pfx_bank.sv
module pfx_bank #(
  parameter int unsigned BANK_IDX   = 0,
  parameter int unsigned ROWS       = 8,
  parameter int unsigned COLS       = 4,
  parameter int unsigned BEATS      = 2,
  parameter int unsigned DQ_W       = 2,
  parameter int unsigned CORE_DELAY = 4,
  localparam int unsigned ROW_W     = $clog2(ROWS),
  localparam int unsigned COL_W     = $clog2(COLS),
  localparam int unsigned CNT_W     = $clog2(CORE_DELAY + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [ROW_W-1:0]            row,
  input  logic [COL_W-1:0]            col,
  input  logic                        take,
  output logic                        word_ready,
  output logic                        busy,
  output logic [BEATS-1:0][DQ_W-1:0]  word
);

  localparam logic [COL_W-1:0] GRP_MASK = COL_W'(BEATS - 1);

  logic [DQ_W-1:0]             cells_q [ROWS][COLS];
  logic [BEATS-1:0][DQ_W-1:0]  fetch_w;
  logic [COL_W-1:0]            beat_col;

  logic [CNT_W-1:0]            cnt_q, cnt_d;
  logic                        full_q, full_d;
  logic [BEATS-1:0][DQ_W-1:0]  buf_q;

  // Core array: contents fixed at reset from the address pattern.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < int'(ROWS); r++) begin
        for (int c = 0; c < int'(COLS); c++) begin
          cells_q[r][c] <= DQ_W'(pfx_dram_pkg::cell_pattern(BANK_IDX, r, c));
        end
      end
    end else begin
      cells_q <= cells_q;
    end
  end

  // Wide row read: the aligned column group, rotated to start at the wanted column.
  always_comb begin
    beat_col = '0;
    for (int k = 0; k < int'(BEATS); k++) begin
      beat_col   = (col & ~GRP_MASK) | ((col + COL_W'(k)) & GRP_MASK);
      fetch_w[k] = cells_q[row][beat_col];
    end
  end

  // Next state of the core-access timer and prefetch buffer occupancy.
  always_comb begin
    cnt_d  = cnt_q;
    full_d = full_q;
    if (start) begin
      cnt_d  = CNT_W'(CORE_DELAY);
      full_d = 1'b1;
    end else begin
      if (cnt_q != '0) begin
        cnt_d = cnt_q - 1'b1;
      end
      if (take) begin
        full_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
      buf_q  <= '0;
    end else begin
      cnt_q  <= cnt_d;
      full_q <= full_d;
      if (start) begin
        buf_q <= fetch_w;
      end
    end
  end

  assign word_ready = full_q && (cnt_q == '0);
  assign busy       = full_q;
  assign word       = buf_q;

endmodule

// File: rtl/pfx_order_fifo.sv
module pfx_order_fifo #(
  parameter int unsigned DEPTH = 2,
  parameter int unsigned ENT_W = 2,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [ENT_W-1:0] push_ent,
  input  logic             pop,
  output logic             head_valid,
  output logic [ENT_W-1:0] head_ent
);

  logic [ENT_W-1:0] slot_q [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [PTR_W:0]   cnt_q, cnt_d;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push) begin
      wr_d = (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    end
    if (pop) begin
      rd_d = (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    end
    if (push && !pop) begin
      cnt_d = cnt_q + 1'b1;
    end else if (pop && !push) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < int'(DEPTH); i++) begin
        slot_q[i] <= '0;
      end
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
      if (push) begin
        slot_q[wr_q] <= push_ent;
      end
    end
  end

  assign head_valid = (cnt_q != '0);
  assign head_ent   = slot_q[rd_q];

endmodule

// File: rtl/pfx_serializer.sv
module pfx_serializer #(
  parameter int unsigned BEATS = 2,
  parameter int unsigned DQ_W  = 2,
  localparam int unsigned IDX_W = $clog2(BEATS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        src_ready,
  input  logic [BEATS-1:0][DQ_W-1:0]  src_word,
  input  logic                        src_keep_all,
  output logic                        take,
  output logic [DQ_W-1:0]             dq_data,
  output logic                        dq_valid,
  output logic                        dq_first,
  output logic                        dq_drop
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BEATS - 1);

  logic                        vld_q, vld_d;
  logic [IDX_W-1:0]            idx_q, idx_d;
  logic                        keep_q, keep_d;
  logic [BEATS-1:0][DQ_W-1:0]  sreg_q;

  always_comb begin
    take   = src_ready && (!vld_q || idx_q == LAST_IDX);
    vld_d  = vld_q;
    idx_d  = idx_q;
    keep_d = keep_q;
    if (take) begin
      vld_d  = 1'b1;
      idx_d  = '0;
      keep_d = src_keep_all;
    end else if (vld_q && idx_q != LAST_IDX) begin
      idx_d = idx_q + 1'b1;
    end else begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      idx_q  <= '0;
      keep_q <= 1'b0;
      sreg_q <= '0;
    end else begin
      vld_q  <= vld_d;
      idx_q  <= idx_d;
      keep_q <= keep_d;
      if (take) begin
        sreg_q <= src_word;
      end
    end
  end

  assign dq_data  = sreg_q[idx_q];
  assign dq_valid = vld_q;
  assign dq_first = vld_q && (idx_q == '0);
  assign dq_drop  = vld_q && (idx_q != '0) && !keep_q;

endmodule

// File: rtl/pfx_dram_model.sv
module pfx_dram_model #(
  parameter int unsigned NUM_BANKS  = 2,
  parameter int unsigned ROWS       = 8,
  parameter int unsigned COLS       = 4,
  parameter int unsigned BURST_LEN  = 2,
  parameter int unsigned DQ_W       = 2,
  parameter int unsigned CORE_DELAY = 4,
  localparam int unsigned BANK_W    = $clog2(NUM_BANKS),
  localparam int unsigned ROW_W     = $clog2(ROWS),
  localparam int unsigned COL_W     = $clog2(COLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_keep_all,
  output logic [DQ_W-1:0]   dq_data,
  output logic              dq_valid,
  output logic              dq_first,
  output logic              dq_drop
);

  localparam int unsigned ENT_W = BANK_W + 1;

  logic                           rst_n_s;
  logic                           accept;
  logic [NUM_BANKS-1:0]           bank_busy;
  logic [NUM_BANKS-1:0]           bank_rdy;
  logic [BURST_LEN-1:0][DQ_W-1:0] bank_word [NUM_BANKS];
  logic                           head_valid;
  logic [ENT_W-1:0]               head_ent;
  logic [BANK_W-1:0]              head_bank;
  logic                           head_keep;
  logic                           ser_take;
  logic                           src_ready;

  pfx_rst_sync rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  assign req_ready = rst_n_s && !bank_busy[req_bank];
  assign accept    = req_valid && req_ready;

  for (genvar b = 0; b < int'(NUM_BANKS); b++) begin : g_bank
    logic start_b;
    logic take_b;
    assign start_b = accept && (req_bank == BANK_W'(b));
    assign take_b  = ser_take && (head_bank == BANK_W'(b));

    pfx_bank #(
      .BANK_IDX   (b),
      .ROWS       (ROWS),
      .COLS       (COLS),
      .BEATS      (BURST_LEN),
      .DQ_W       (DQ_W),
      .CORE_DELAY (CORE_DELAY)
    ) bank_i (
      .clk        (clk),
      .rst_n      (rst_n_s),
      .start      (start_b),
      .row        (req_row),
      .col        (req_col),
      .take       (take_b),
      .word_ready (bank_rdy[b]),
      .busy       (bank_busy[b]),
      .word       (bank_word[b])
    );
  end

  // Request order record: each bank holds at most one access, so NUM_BANKS slots suffice.
  pfx_order_fifo #(
    .DEPTH (NUM_BANKS),
    .ENT_W (ENT_W)
  ) order_i (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .push       (accept),
    .push_ent   ({req_keep_all, req_bank}),
    .pop        (ser_take),
    .head_valid (head_valid),
    .head_ent   (head_ent)
  );

  assign head_bank = head_ent[BANK_W-1:0];
  assign head_keep = head_ent[ENT_W-1];
  assign src_ready = head_valid && bank_rdy[head_bank];

  pfx_serializer #(
    .BEATS (BURST_LEN),
    .DQ_W  (DQ_W)
  ) ser_i (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .src_ready    (src_ready),
    .src_word     (bank_word[head_bank]),
    .src_keep_all (head_keep),
    .take         (ser_take),
    .dq_data      (dq_data),
    .dq_valid     (dq_valid),
    .dq_first     (dq_first),
    .dq_drop      (dq_drop)
  );

endmodule

// File: rtl/pfx_dram_model_chk.sv
module pfx_dram_model_chk #(
  parameter int unsigned BURST_LEN = 2,
  parameter int unsigned BANK_W    = 1,
  localparam int unsigned RUN_W    = $clog2(BURST_LEN + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [BANK_W-1:0] req_bank,
  input logic              dq_valid,
  input logic              dq_first,
  input logic              dq_drop
);

  logic [RUN_W-1:0] run_q;
  logic [7:0]       pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      pend_q <= '0;
    end else begin
      run_q <= !dq_valid ? '0 : (dq_first ? RUN_W'(1) : run_q + 1'b1);
      if ((req_valid && req_ready) && !dq_first) begin
        pend_q <= pend_q + 1'b1;
      end else if (!(req_valid && req_ready) && dq_first) begin
        pend_q <= pend_q - 1'b1;
      end
    end
  end

  AST_FIRST_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n) (dq_valid && dq_first) |-> !dq_drop); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !dq_valid |-> (!dq_first && !dq_drop)); // R3
  AST_BEAT_RUN: assert property (@(posedge clk) disable iff (!rst_n) (dq_valid && !dq_first) |-> (run_q != '0 && run_q < RUN_W'(BURST_LEN))); // R3
  AST_BURST_FULL: assert property (@(posedge clk) disable iff (!rst_n) ((dq_first || !dq_valid) && run_q != '0) |-> (run_q == RUN_W'(BURST_LEN))); // R3
  AST_BANK_LOCK: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_ready) ##1 (req_bank == $past(req_bank)) |-> !req_ready); // R6
  AST_FIRST_OWED: assert property (@(posedge clk) disable iff (!rst_n) dq_first |-> (pend_q != '0)); // R7

endmodule

bind pfx_dram_model pfx_dram_model_chk #(
  .BURST_LEN (BURST_LEN),
  .BANK_W    (BANK_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_bank  (req_bank),
  .dq_valid  (dq_valid),
  .dq_first  (dq_first),
  .dq_drop   (dq_drop)
);

// File: tb/pfx_dram_model_tb_top.sv
`timescale 1ns/100ps
module pfx_dram_model_tb_top;

  localparam int NB     = 2;
  localparam int ROWS   = 8;
  localparam int COLS   = 4;
  localparam int BL     = 2;
  localparam int DQW    = 2;
  localparam int DLY    = 4;
  localparam int BANK_W = $clog2(NB);
  localparam int ROW_W  = $clog2(ROWS);
  localparam int COL_W  = $clog2(COLS);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [BANK_W-1:0] req_bank = '0;
  logic [ROW_W-1:0]  req_row = '0;
  logic [COL_W-1:0]  req_col = '0;
  logic              req_keep_all = 1'b0;
  logic [DQW-1:0]    dq_data;
  logic              dq_valid;
  logic              dq_first;
  logic              dq_drop;

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  pfx_dram_model #(
    .NUM_BANKS  (NB),
    .ROWS       (ROWS),
    .COLS       (COLS),
    .BURST_LEN  (BL),
    .DQ_W       (DQW),
    .CORE_DELAY (DLY)
  ) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_bank     (req_bank),
    .req_row      (req_row),
    .req_col      (req_col),
    .req_keep_all (req_keep_all),
    .dq_data      (dq_data),
    .dq_valid     (dq_valid),
    .dq_first     (dq_first),
    .dq_drop      (dq_drop)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int pat(input int b, input int r, input int c);
    return (5 * r + 3 * c + 7 * b + 1) % (1 << DQW);
  endfunction

  function automatic int bcol(input int c, input int k);
    return (c & ~(BL - 1)) | ((c + k) & (BL - 1));
  endfunction

  int q_bank [16];
  int q_row  [16];
  int q_col  [16];
  bit q_all  [16];
  int nq;
  int acc_edge   [16];
  int first_edge [16];
  int last_edge;
  int idle_cnt;
  int stall_cnt;
  int idle_single;

  task automatic set_req(input int i, input int b, input int r, input int c, input bit a);
    q_bank[i] = b; q_row[i] = r; q_col[i] = c; q_all[i] = a;
  endtask

  task automatic send_all();
    stall_cnt = 0;
    for (int i = 0; i < nq; i++) begin
      @(negedge clk);
      req_valid    = 1'b1;
      req_bank     = BANK_W'(q_bank[i]);
      req_row      = ROW_W'(q_row[i]);
      req_col      = COL_W'(q_col[i]);
      req_keep_all = q_all[i];
      #0.5;
      while (!req_ready) begin
        stall_cnt++;
        @(negedge clk);
        #0.5;
      end
      @(posedge clk);
      #0.5;
      acc_edge[i] = cyc;
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic watch_beats();
    int got;
    got = 0;
    idle_cnt = 0;
    while (got < nq * BL) begin
      @(negedge clk);
      if (dq_valid) begin
        int i, k, c;
        i = got / BL;
        k = got % BL;
        c = bcol(q_col[i], k);
        if (k == 0) first_edge[i] = cyc;
        chk(dq_first == (k == 0), "R3 first marker", int'(dq_first), int'(k == 0));
        chk(dq_drop == (k != 0 && !q_all[i]), "R5 drop flag", int'(dq_drop), int'(k != 0 && !q_all[i]));
        chk(int'(dq_data) == pat(q_bank[i], q_row[i], c), "R7 order and R4 beat data",
            int'(dq_data), pat(q_bank[i], q_row[i], c));
        last_edge = cyc;
        got++;
      end else if (got > 0) begin
        idle_cnt++;
      end
    end
  endtask

  task automatic run_stream();
    fork
      send_all();
      watch_beats();
    join
  endtask

  task automatic t_reset();
    chk(dq_valid == 1'b0, "R1 valid low after reset", int'(dq_valid), 0);
    chk(dq_first == 1'b0 && dq_drop == 1'b0, "R1 flags low after reset", int'(dq_first | dq_drop), 0);
    for (int b = 0; b < NB; b++) begin
      @(negedge clk);
      req_bank = BANK_W'(b);
      #0.5;
      chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    end
  endtask

  task automatic t_latency();
    nq = 1;
    set_req(0, 1, 5, 3, 1'b0);
    run_stream();
    chk(first_edge[0] - acc_edge[0] == DLY + 1, "R2 first beat latency",
        first_edge[0] - acc_edge[0], DLY + 1);
  endtask

  task automatic t_keep_all();
    nq = 3;
    set_req(0, 0, 2, 1, 1'b1);
    set_req(1, 1, 7, 0, 1'b1);
    set_req(2, 0, 6, 3, 1'b0);
    run_stream();
  endtask

  task automatic t_single_bank();
    nq = 4;
    set_req(0, 0, 0, 0, 1'b0);
    set_req(1, 0, 3, 1, 1'b0);
    set_req(2, 0, 6, 2, 1'b0);
    set_req(3, 0, 1, 3, 1'b0);
    run_stream();
    chk(stall_cnt == 3 * (DLY + 1), "R6 ready low while bank holds access", stall_cnt, 3 * (DLY + 1));
    for (int i = 1; i < 4; i++)
      chk(acc_edge[i] - acc_edge[i-1] == DLY + 2, "R6 single-bank acceptance spacing",
          acc_edge[i] - acc_edge[i-1], DLY + 2);
    chk(last_edge - acc_edge[0] == DLY + 1 + 3 * (DLY + 2) + BL - 1, "R9 single-bank stream length",
        last_edge - acc_edge[0], DLY + 1 + 3 * (DLY + 2) + BL - 1);
    chk(idle_cnt == 3 * (DLY + 2 - BL), "R9 single-bank idle cycles", idle_cnt, 3 * (DLY + 2 - BL));
    idle_single = idle_cnt;
  endtask

  task automatic t_alternating();
    nq = 4;
    set_req(0, 0, 4, 3, 1'b0);
    set_req(1, 1, 2, 0, 1'b0);
    set_req(2, 0, 7, 1, 1'b0);
    set_req(3, 1, 5, 2, 1'b0);
    run_stream();
    chk(first_edge[1] - first_edge[0] == BL, "R8 no gap between overlapped bursts",
        first_edge[1] - first_edge[0], BL);
    chk(first_edge[3] - first_edge[2] == BL, "R8 no gap second pair",
        first_edge[3] - first_edge[2], BL);
    chk(last_edge - acc_edge[0] == DLY + 1 + (DLY + 2) + 2 * BL - 1, "R10 alternating stream length",
        last_edge - acc_edge[0], DLY + 1 + (DLY + 2) + 2 * BL - 1);
    chk(idle_cnt == DLY + 2 - 2 * BL, "R10 alternating idle cycles", idle_cnt, DLY + 2 - 2 * BL);
    chk(idle_cnt < idle_single, "R10 fewer idle cycles than single bank", idle_cnt, idle_single);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog expired", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_latency();
    t_keep_all();
    t_single_bank();
    t_alternating();
    repeat (4) @(negedge clk);
    chk(dq_valid == 1'b0, "R3 pins idle after streams", int'(dq_valid), 0);
    summary();
    $finish;
  end

endmodule